// File: doc/BRIEF.md
# Byte Parity Generate and Check Unit

This block guards a synchronous SRAM data path of 16 or 32 bits with one even parity bit per 8-bit byte. It holds a small behavioural storage array and places a parity stage in front of it and behind it. When the system has no parity source (internal parity), the unit makes the parity bits itself on every write. It stores them with the word. On every read it computes parity again and compares it with the stored bits. When the system does supply parity (external parity), the unit checks each incoming write word against the supplied bits and stores them as given. A single active-low error output reports a mismatch.

Two inputs select the modes. `ext_par_mode` chooses internal or external parity. `pipe_mode` chooses flow-through or pipelined timing. Pipelined timing adds one register stage to read data and delays every error report by one cycle. Storage that has never been written holds unknown parity, so a clearing pass is built in. A controller with three states, ST_UNINIT, ST_CLEAR and ST_READY, runs that pass. START (ST_UNINIT to ST_CLEAR) and RESTART (ST_READY to ST_CLEAR) both fire on `init_start`. FINISH (ST_CLEAR to ST_READY) fires once the last address has been cleared.

Top module: `byte_parity_unit`

## Requirements
- R1: Parity bit k covers data bits [8k+7:8k], and it is chosen so that those nine bits hold an even number of ones; a byte of 0x00 has parity 0.
- R2: With `ext_par_mode`=0, `wr_par` is ignored: no write error is raised, and the stored parity is the generated parity of the written word.
- R3: With `ext_par_mode`=0, `rd_par_oe` is 0 and `rd_par` is all zeros in every cycle.
- R4: With `ext_par_mode`=1, the stored parity is `wr_par` as supplied. A read presents it on `rd_par` with `rd_par_oe`=1 while `rd_valid` is 1.
- R5: In flow-through timing (`pipe_mode`=0) with external parity, an accepted write whose `wr_par` differs from the parity of `wr_data` drives `par_err_n` low in the cycle after the edge that accepted it.
- R6: In pipelined timing (`pipe_mode`=1), that write error appears one cycle later than in R5.
- R7: Read data appears with `rd_valid`=1 in the cycle after the accepting edge in flow-through timing, and two cycles after it in pipelined timing. It appears for exactly one cycle.
- R8: When presented read data fails the parity check, `par_err_n` goes low in the cycle after the data is presented. This happens in either parity mode.
- R9: `par_err_n` is low for exactly one cycle per erroneous access and high in every other cycle.
- R10: An `init_start` sampled in ST_UNINIT or ST_READY starts a pass that writes zero data with zero parity to each of the 2^ADDR_W addresses, one per cycle. `init_done` is low during the pass and high from the cycle after its last write.
- R11: Requests sampled during the clearing pass are ignored. They produce no read data, no error and no change to storage.
- R12: After reset, `init_done` is 0, `rd_valid` is 0 and `par_err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_par_mode | input | 1 | 1 = parity supplied on the bus, 0 = generated internally |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through timing |
| init_start | input | 1 | Starts the clearing pass |
| init_done | output | 1 | Clearing pass complete |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| wr_par | input | DATA_W/8 | Write parity, one bit per byte |
| rd_valid | output | 1 | Read data presented |
| rd_data | output | DATA_W | Read data |
| rd_par | output | DATA_W/8 | Stored parity (zero in internal mode) |
| rd_par_oe | output | 1 | Drive enable for the parity bits |
| par_err_n | output | 1 | Active-low parity error pulse |

## Verification
The assertions check the following on every cycle:
- the parity bits are never driven in internal mode;
- a bad external write parity leads to an error pulse at the latency set by the mode;
- a flow-through read is answered on the next cycle;
- no read data comes out during clearing;
- `init_done` only rises as a clearing pass ends.

Only the bench scenarios can show the rest:
- that stored parity is kept and returned correctly;
- that read-side errors follow bad stored parity through a change of mode;
- that the clearing pass takes exactly one cycle per address and leaves zeros behind;
- that writes issued during clearing leave no trace.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    typedef enum logic [1:0] {
        ST_UNINIT = 2'd0,
        ST_CLEAR  = 2'd1,
        ST_READY  = 2'd2
    } bpu_state_e;
endpackage

// File: rtl/bpu_pargen.sv
module bpu_pargen #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] par
);
    localparam int NB = DATA_W / 8;

    // R1: one even parity bit per byte lane
    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign par[k] = ^data[8*k +: 8];
    end
endmodule

// File: rtl/bpu_store.sv
module bpu_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wpar,
    input  logic                re,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [DATA_W-1:0]   q_data,
    output logic [DATA_W/8-1:0] q_par
);
    localparam int NB    = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WW    = DATA_W + NB;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {wpar, wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_par  <= '0;
        end else if (re) begin
            {q_par, q_data} <= mem[raddr];
        end
    end
endmodule

// File: rtl/bpu_seq.sv
module bpu_seq
    import bpu_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_start,
    output logic              clearing,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              init_done
);
    bpu_state_e        state, nxt;
    logic [ADDR_W-1:0] cnt;
    logic              last;

    assign last = &cnt;

    // state register and sweep counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UNINIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CLEAR) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // transitions: START, FINISH, RESTART
    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNINIT: if (init_start) nxt = ST_CLEAR;
            ST_CLEAR:  if (last)       nxt = ST_READY;
            ST_READY:  if (init_start) nxt = ST_CLEAR;
            default:                   nxt = ST_UNINIT;
        endcase
    end

    // outputs
    always_comb begin
        clearing  = 1'b0;
        init_done = 1'b0;
        clr_addr  = cnt;
        unique case (state)
            ST_UNINIT: ;
            ST_CLEAR:  clearing  = 1'b1;
            ST_READY:  init_done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_par_mode,
    input  logic                pipe_mode,
    input  logic                init_start,
    output logic                init_done,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_par,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W/8-1:0] rd_par,
    output logic                rd_par_oe,
    output logic                par_err_n
);
    localparam int NB = DATA_W / 8;

    logic              clearing;
    logic [ADDR_W-1:0] clr_addr;
    logic              accept, mem_we, mem_re;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata, q_data, s2_data, o_data;
    logic [NB-1:0]     mem_wpar, q_par, s2_par, o_par, wr_gen, o_gen;
    logic              s1_v, s2_v, o_v;
    logic              werr1, werr2, rerr_q;

    bpu_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_start (init_start),
        .clearing   (clearing),
        .clr_addr   (clr_addr),
        .init_done  (init_done)
    );

    bpu_pargen #(.DATA_W(DATA_W)) u_wgen (
        .data (wr_data),
        .par  (wr_gen)
    );

    // R11: requests are dropped while the sweep runs
    assign accept    = req_valid & ~clearing;
    assign mem_we    = clearing | (accept & req_write);
    assign mem_re    = accept & ~req_write;
    assign mem_waddr = clearing ? clr_addr : req_addr;
    assign mem_wdata = clearing ? '0 : wr_data;
    assign mem_wpar  = clearing ? '0 : (ext_par_mode ? wr_par : wr_gen);

    bpu_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .wpar   (mem_wpar),
        .re     (mem_re),
        .raddr  (req_addr),
        .q_data (q_data),
        .q_par  (q_par)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s2_v    <= 1'b0;
            s2_data <= '0;
            s2_par  <= '0;
            werr1   <= 1'b0;
            werr2   <= 1'b0;
            rerr_q  <= 1'b0;
        end else begin
            s1_v    <= mem_re;
            s2_v    <= s1_v;
            s2_data <= q_data;
            s2_par  <= q_par;
            werr1   <= accept & req_write & ext_par_mode & (wr_gen != wr_par);
            werr2   <= werr1;
            rerr_q  <= o_v & (o_gen != o_par);
        end
    end

    // output stage: flow-through takes the array register, pipelined one more
    assign o_v    = pipe_mode ? s2_v    : s1_v;
    assign o_data = pipe_mode ? s2_data : q_data;
    assign o_par  = pipe_mode ? s2_par  : q_par;

    bpu_pargen #(.DATA_W(DATA_W)) u_rgen (
        .data (o_data),
        .par  (o_gen)
    );

    assign rd_valid  = o_v;
    assign rd_data   = o_data;
    assign rd_par_oe = ext_par_mode & o_v;
    assign rd_par    = rd_par_oe ? o_par : '0;
    assign par_err_n = ~((pipe_mode ? werr2 : werr1) | rerr_q);
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ext_par_mode,
    input logic                pipe_mode,
    input logic                req_valid,
    input logic                req_write,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W/8-1:0] wr_par,
    input logic                clearing,
    input logic                init_done,
    input logic                rd_valid,
    input logic [DATA_W/8-1:0] rd_par,
    input logic                rd_par_oe,
    input logic                par_err_n
);
    localparam int NB = DATA_W / 8;

    function automatic logic [NB-1:0] even_par(input logic [DATA_W-1:0] d);
        logic [NB-1:0] p;
        for (int k = 0; k < NB; k++) p[k] = ^d[8*k +: 8];
        return p;
    endfunction

    logic bad_wr;
    assign bad_wr = req_valid & req_write & ~clearing & ext_par_mode
                    & (even_par(wr_data) != wr_par);

    assert_no_ninth_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_par_mode |-> (!rd_par_oe && rd_par == '0));

    assert_ft_write_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && !pipe_mode) |=> !par_err_n);

    assert_pipe_write_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && pipe_mode) |=> ##1 !par_err_n);

    assert_ft_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !clearing && !pipe_mode) |=> rd_valid);

    assert_clear_ignores_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && !pipe_mode) |=> (pipe_mode || !rd_valid));

    assert_done_after_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(clearing));

    assert_done_low_in_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> !init_done);
endmodule

bind byte_parity_unit bpu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_par_mode (ext_par_mode),
    .pipe_mode    (pipe_mode),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .wr_data      (wr_data),
    .wr_par       (wr_par),
    .clearing     (clearing),
    .init_done    (init_done),
    .rd_valid     (rd_valid),
    .rd_par       (rd_par),
    .rd_par_oe    (rd_par_oe),
    .par_err_n    (par_err_n)
);

// File: tb/tb_byte_parity_unit.sv
module tb_byte_parity_unit;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int NB     = DATA_W / 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_par_mode = 1'b0, pipe_mode = 1'b0, init_start = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NB-1:0]     wr_par = '0;
    logic              init_done, rd_valid, rd_par_oe, par_err_n;
    logic [DATA_W-1:0] rd_data;
    logic [NB-1:0]     rd_par;

    int checks = 0;
    int fails  = 0;

    logic [DATA_W-1:0] m_data [DEPTH];
    logic [NB-1:0]     m_par  [DEPTH];

    always #4 clk = ~clk;

    byte_parity_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (.*);

    function automatic logic [NB-1:0] gen_par(input logic [DATA_W-1:0] d);
        logic [NB-1:0] p;
        for (int k = 0; k < NB; k++) p[k] = ^d[8*k +: 8];
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // one isolated access; starts and ends at a negedge
    task automatic run_op(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic [NB-1:0] p,
                          input bit ext, input bit pipe);
        bit werr, rerr;
        logic [DATA_W-1:0] ed;
        logic [NB-1:0] ep;
        ext_par_mode = ext; pipe_mode = pipe;
        req_valid = 1'b1; req_write = wr; req_addr = a; wr_data = d; wr_par = p;
        werr = wr && ext && (gen_par(d) != p);          // R5/R6, R2
        ed = m_data[a]; ep = m_par[a];
        rerr = !wr && (gen_par(ed) != ep);              // R8
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        // first cycle after acceptance
        check("R5 err cycle1", {63'd0, par_err_n}, {63'd0, !(!pipe && werr)});
        check("R7 valid cycle1", {63'd0, rd_valid}, {63'd0, (!wr && !pipe)});
        if (!wr && !pipe) begin
            check("R7 data ft", {32'd0, rd_data}, {32'd0, ed});
            check("R3/R4 par ft", {59'd0, rd_par_oe, rd_par}, {59'd0, ext, ext ? ep : 4'h0});
        end
        @(negedge clk);
        check("R6/R8 err cycle2", {63'd0, par_err_n},
              {63'd0, !((pipe && werr) || (!pipe && rerr))});
        check("R7 valid cycle2", {63'd0, rd_valid}, {63'd0, (!wr && pipe)});
        if (!wr && pipe) begin
            check("R7 data pipe", {32'd0, rd_data}, {32'd0, ed});
            check("R3/R4 par pipe", {59'd0, rd_par_oe, rd_par}, {59'd0, ext, ext ? ep : 4'h0});
        end
        @(negedge clk);
        check("R8/R9 err cycle3", {63'd0, par_err_n}, {63'd0, !(pipe && rerr)});
        check("R9 valid cycle3", {63'd0, rd_valid}, 64'd0);
        if (wr) begin
            m_data[a] = d;
            m_par[a]  = ext ? p : gen_par(d);   // R2, R4
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12 init_done", {63'd0, init_done}, 64'd0);
        check("R12 rd_valid", {63'd0, rd_valid}, 64'd0);
        check("R12 par_err_n", {63'd0, par_err_n}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        // preload a word so the sweep must overwrite it
        run_op(1'b1, 5'd3, 32'hA5A5_1234, 4'h0, 1'b0, 1'b0);
        // R10/R11: sweep, with bad traffic during it
        init_start = 1'b1;
        @(posedge clk); @(negedge clk);
        init_start = 1'b0;
        n = 0;
        for (int i = 0; i < DEPTH + 4 && !init_done; i++) begin
            n++;
            check("R11 no read during clear", {63'd0, rd_valid}, 64'd0);
            check("R11 no error during clear", {63'd0, par_err_n}, 64'd1);
            ext_par_mode = 1'b1;
            req_valid = 1'b1; req_write = i[0]; req_addr = 5'd3;
            wr_data = 32'hDEAD_BEEF; wr_par = ~gen_par(32'hDEAD_BEEF);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R10 sweep length", 64'(n), 64'(DEPTH));
        check("R10 init_done", {63'd0, init_done}, 64'd1);
        for (int a = 0; a < DEPTH; a++) begin
            m_data[a] = '0;
            m_par[a]  = '0;
        end
        @(negedge clk);
        // R10/R11: cleared word reads zero, bad writes during sweep left no trace
        run_op(1'b0, 5'd3, '0, '0, 1'b1, 1'b0);
        run_op(1'b0, 5'd31, '0, '0, 1'b1, 1'b1);
        // directed corner cases
        run_op(1'b1, 5'd1, 32'h0000_0001, 4'h0, 1'b1, 1'b0);   // R5 bad lane 0
        run_op(1'b1, 5'd2, 32'h0100_0000, 4'h0, 1'b1, 1'b1);   // R6 bad lane 3
        run_op(1'b0, 5'd1, '0, '0, 1'b0, 1'b0);                // R8 stored bad, R3
        run_op(1'b0, 5'd2, '0, '0, 1'b1, 1'b1);                // R8 pipe, R4
        run_op(1'b1, 5'd4, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0);   // R2 wr_par ignored
        run_op(1'b0, 5'd4, '0, '0, 1'b1, 1'b0);                // R1 R4 parity 0000
        run_op(1'b1, 5'd5, 32'h0103_0700, 4'hA, 1'b1, 1'b0);   // R1 good parity
        // constrained random mix
        for (int i = 0; i < 500; i++) begin
            logic [DATA_W-1:0] d;
            logic [NB-1:0] p;
            d = $urandom;
            p = ($urandom_range(0, 3) == 0) ? NB'($urandom) : gen_par(d);
            run_op(1'($urandom_range(0, 1)), ADDR_W'($urandom_range(0, 7)), d, p,
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        // R10: restart from ready clears again
        init_start = 1'b1;
        @(posedge clk); @(negedge clk);
        init_start = 1'b0;
        check("R10 done low on restart", {63'd0, init_done}, 64'd0);
        repeat (DEPTH) @(negedge clk);
        check("R10 done after restart", {63'd0, init_done}, 64'd1);
        for (int a = 0; a < DEPTH; a++) begin
            m_data[a] = '0;
            m_par[a]  = '0;
        end
        run_op(1'b0, 5'd5, '0, '0, 1'b1, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule